// File: doc/BRIEF.md
# Sixteen-Bit Output Compare Channel

This block holds a 16-bit compare value and watches a free-running count that comes in from outside. The count arrives with an increment strobe. On each strobed count that equals the stored value, the block raises a compare flag and copies a programmed level bit into the register that drives the compare pin. If the interrupt enable is set while the flag is up, the interrupt output is asserted. The block does not contain the counter or the processor. It sees a simple byte-wide register port: a write strobe with an address, and a read strobe with an address and combinational read data.

A host writes the compare value one byte at a time. To stop a half-updated value from producing a false match, a write-sequencing state machine handles the two bytes. A write to the high byte moves it from `SEQ_ARMED` to `SEQ_HALF`, and matching is suppressed there. A write to the low byte moves it back to `SEQ_ARMED`. A low-byte write on its own leaves it in `SEQ_ARMED`.

A second state machine tracks the flag:
- `FLG_CLEAR` goes to `FLG_SET` on a match.
- `FLG_SET` goes to `FLG_SEEN` when the status register is read.
- `FLG_SEEN` goes to `FLG_CLEAR` on a low-byte write, or back to `FLG_SET` if a match happens in that same cycle.

Reset does not touch the compare bytes, so they can serve as plain storage.

Top module: `oc_unit`

## Requirements
- R1: After reset the compare pin is 0, the interrupt is 0, the control register reads 0 and the status register reads 0 (flag clear, matching not inhibited, pin 0).
- R2: Address 0 is the high byte and address 1 is the low byte of the compare value. Each is written and read back in full, and a write to one leaves the other unchanged.
- R3: A match occurs when the count strobe is high, matching is not inhibited and the count equals {high, low}. One clock after a match the flag is set.
- R4: One clock after every match the compare pin equals the level bit sampled in the match cycle, whether or not the flag was already set.
- R5: After a high-byte write, no strobed count produces a match until a low-byte write has completed. Matching resumes from the clock after that write.
- R6: A low-byte write that is not preceded by a pending high-byte write keeps matching enabled, and the new value can match on the very next strobe.
- R7: The interrupt output is high exactly when the flag is set and the enable bit is set.
- R8: With the strobe low, or with the count not equal, the compare pin does not change.
- R9: The flag is cleared only by a low-byte write that follows a status read made while the flag was set. A low-byte write without such a read leaves the flag set.
- R10: If a clearing low-byte write coincides with a new match, the flag stays set.
- R11: Address 2 is control: bit 0 is the level bit, bit 1 is the interrupt enable, and the other bits read 0. Address 3 is status: bit 7 is the flag, bit 6 is 1 while matching is inhibited, bit 0 mirrors the compare pin. Writes to status are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_en | input | 1 | Register read strobe (status reads arm flag clearing) |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Combinational read data |
| cnt_val | input | 16 | Free-running count value |
| cnt_tick | input | 1 | Count increment strobe; matches are evaluated only when high |
| cmp_pin | output | 1 | Compare output level register |
| irq | output | 1 | Compare interrupt request |

## Verification
Suppose the sequencer wrongly stays in `SEQ_HALF`, or wrongly stays armed. The fault shows on the first strobed count that equals the stored value: `cmp_pin` and `irq` fail to move, or move when they should not, one clock after that strobe. Status bit 6 also exposes the inhibit state at once. A flag state machine stuck in the wrong state becomes visible through `irq` and status bit 7 on the cycle after the low-byte write that should, or should not, clear it. A stale level bit shows on the pin one clock after the next match.

// File: rtl/oc_pkg.sv
package oc_pkg;
    localparam int unsigned ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_HI   = 2'd0;
    localparam logic [ADDR_W-1:0] A_LO   = 2'd1;
    localparam logic [ADDR_W-1:0] A_CTRL = 2'd2;
    localparam logic [ADDR_W-1:0] A_STAT = 2'd3;

    localparam int unsigned CTRL_LVL_BIT = 0;
    localparam int unsigned CTRL_IE_BIT  = 1;
    localparam int unsigned STAT_PIN_BIT = 0;

    typedef enum logic {
        SEQ_ARMED = 1'b0,
        SEQ_HALF  = 1'b1
    } seq_state_e;

    typedef enum logic [1:0] {
        FLG_CLEAR = 2'd0,
        FLG_SET   = 2'd1,
        FLG_SEEN  = 2'd2
    } flg_state_e;
endpackage

// File: rtl/oc_wr_seq.sv
module oc_wr_seq
    import oc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hi_wr,
    input  logic lo_wr,
    output logic armed
);
    seq_state_e st_q, st_d;

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SEQ_ARMED: if (hi_wr) st_d = SEQ_HALF;
            SEQ_HALF:  if (lo_wr) st_d = SEQ_ARMED;
            default:   st_d = SEQ_ARMED;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= SEQ_ARMED;
        else        st_q <= st_d;
    end

    // outputs
    always_comb begin
        armed = (st_q == SEQ_ARMED);
    end
endmodule

// File: rtl/oc_flag_fsm.sv
module oc_flag_fsm
    import oc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic match_evt,
    input  logic stat_rd,
    input  logic lo_wr,
    output logic flag
);
    flg_state_e st_q, st_d;

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            FLG_CLEAR: if (match_evt) st_d = FLG_SET;
            FLG_SET:   if (stat_rd)   st_d = FLG_SEEN;
            FLG_SEEN:  if (lo_wr)     st_d = match_evt ? FLG_SET : FLG_CLEAR;
            default:   st_d = FLG_CLEAR;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= FLG_CLEAR;
        else        st_q <= st_d;
    end

    // outputs
    always_comb begin
        flag = (st_q != FLG_CLEAR);
    end
endmodule

// File: rtl/oc_regs.sv
module oc_regs
    import oc_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [DATA_W-1:0]     wr_data,
    output logic [2*DATA_W-1:0]   cmp_val,
    output logic                  lvl_bit,
    output logic                  ie_bit
);
    localparam int unsigned NBYTES = 2;

    // compare bytes: byte 0 is low, byte 1 is high; not reset
    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        localparam logic [ADDR_W-1:0] SEL = (b == 0) ? A_LO : A_HI;
        logic [DATA_W-1:0] byte_q;
        always_ff @(posedge clk) begin
            if (wr_en && (wr_addr == SEL)) byte_q <= wr_data;
        end
        assign cmp_val[b*DATA_W +: DATA_W] = byte_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_bit <= 1'b0;
            ie_bit  <= 1'b0;
        end else if (wr_en && (wr_addr == A_CTRL)) begin
            lvl_bit <= wr_data[CTRL_LVL_BIT];
            ie_bit  <= wr_data[CTRL_IE_BIT];
        end
    end
endmodule

// File: rtl/oc_match.sv
module oc_match #(
    parameter int unsigned CMP_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_tick,
    input  logic [CMP_W-1:0] cnt_val,
    input  logic [CMP_W-1:0] cmp_val,
    input  logic             armed,
    input  logic             lvl_bit,
    output logic             match_evt,
    output logic             pin
);
    always_comb begin
        match_evt = cnt_tick && armed && (cnt_val == cmp_val);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         pin <= 1'b0;
        else if (match_evt) pin <= lvl_bit;
    end
endmodule

// File: rtl/oc_unit.sv
module oc_unit
    import oc_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    localparam int unsigned CMP_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [1:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [CMP_W-1:0]  cnt_val,
    input  logic              cnt_tick,
    output logic              cmp_pin,
    output logic              irq
);
    localparam int unsigned STAT_FLAG_BIT = DATA_W - 1;
    localparam int unsigned STAT_INH_BIT  = DATA_W - 2;

    logic             hi_wr, lo_wr, stat_rd;
    logic             armed, flag, match_evt;
    logic             lvl_bit, ie_bit;
    logic [CMP_W-1:0] cmp_val;

    assign hi_wr   = wr_en && (wr_addr == A_HI);
    assign lo_wr   = wr_en && (wr_addr == A_LO);
    assign stat_rd = rd_en && (rd_addr == A_STAT);

    oc_regs #(.DATA_W(DATA_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cmp_val (cmp_val),
        .lvl_bit (lvl_bit),
        .ie_bit  (ie_bit)
    );

    oc_wr_seq u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .hi_wr (hi_wr),
        .lo_wr (lo_wr),
        .armed (armed)
    );

    oc_match #(.CMP_W(CMP_W)) u_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_tick  (cnt_tick),
        .cnt_val   (cnt_val),
        .cmp_val   (cmp_val),
        .armed     (armed),
        .lvl_bit   (lvl_bit),
        .match_evt (match_evt),
        .pin       (cmp_pin)
    );

    oc_flag_fsm u_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .match_evt (match_evt),
        .stat_rd   (stat_rd),
        .lo_wr     (lo_wr),
        .flag      (flag)
    );

    assign irq = flag && ie_bit;

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            A_HI:   rd_data = cmp_val[CMP_W-1:DATA_W];
            A_LO:   rd_data = cmp_val[DATA_W-1:0];
            A_CTRL: begin
                rd_data[CTRL_LVL_BIT] = lvl_bit;
                rd_data[CTRL_IE_BIT]  = ie_bit;
            end
            A_STAT: begin
                rd_data[STAT_FLAG_BIT] = flag;
                rd_data[STAT_INH_BIT]  = ~armed;
                rd_data[STAT_PIN_BIT]  = cmp_pin;
            end
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/oc_unit_chk.sv
module oc_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [1:0] wr_addr,
    input logic       match_evt,
    input logic       armed,
    input logic       flag,
    input logic       lvl_bit,
    input logic       cmp_pin,
    input logic       irq
);
    a_r3_flag_after_match: assert property (@(posedge clk) disable iff (!rst_n)
        match_evt |=> flag);

    a_r4_pin_takes_level: assert property (@(posedge clk) disable iff (!rst_n)
        match_evt |=> (cmp_pin == $past(lvl_bit)));

    a_r8_pin_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !match_evt |=> $stable(cmp_pin));

    a_r5_high_write_inhibits: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd0) |=> !armed);

    a_r6_low_write_arms: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd1) |=> armed);

    a_r7_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flag);

    a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !(wr_en && wr_addr == 2'd1)) |=> flag);
endmodule

bind oc_unit oc_unit_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .match_evt (match_evt),
    .armed     (armed),
    .flag      (flag),
    .lvl_bit   (lvl_bit),
    .cmp_pin   (cmp_pin),
    .irq       (irq)
);

// File: tb/oc_unit_tb_top.sv
`timescale 1ns/1ps
module oc_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        rd_en = 1'b0;
    logic [1:0]  rd_addr = '0;
    logic [7:0]  rd_data;
    logic [15:0] cnt_val = '0;
    logic        cnt_tick = 1'b0;
    logic        cmp_pin;
    logic        irq;

    int total = 0;
    int bad   = 0;

    // reference model state
    logic [7:0] m_hi = '0, m_lo = '0;
    bit m_hi_ok = 0, m_lo_ok = 0;
    bit m_lvl = 0, m_ie = 0, m_armed = 1, m_pin = 0;
    int m_flg = 0; // 0 clear, 1 set, 2 set and seen by status read

    always #5 clk = ~clk;

    oc_unit dut_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .cnt_val(cnt_val), .cnt_tick(cnt_tick),
        .cmp_pin(cmp_pin), .irq(irq)
    );

    task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] model_rd(input logic [1:0] ra);
        case (ra)
            2'd0:    return m_hi;
            2'd1:    return m_lo;
            2'd2:    return {6'b0, m_ie, m_lvl};
            default: return {(m_flg != 0), !m_armed, 5'b0, m_pin};
        endcase
    endfunction

    // one clock: drive at negedge, check reads before the edge, outputs after
    task automatic cyc(input bit we, input logic [1:0] wa, input logic [7:0] wd,
                       input bit re, input logic [1:0] ra,
                       input bit tk, input logic [15:0] cv, input string tag);
        bit mt;
        wr_en = we; wr_addr = wa; wr_data = wd;
        rd_en = re; rd_addr = ra;
        cnt_tick = tk; cnt_val = cv;
        #1;
        if (re && (ra >= 2 || (ra == 0 && m_hi_ok) || (ra == 1 && m_lo_ok)))
            check(rd_data === model_rd(ra), tag, {8'h0, rd_data}, {8'h0, model_rd(ra)});
        mt = tk && m_armed && m_hi_ok && m_lo_ok && (cv == {m_hi, m_lo});
        case (m_flg)
            0: if (mt) m_flg = 1;
            1: if (re && ra == 2'd3) m_flg = 2;
            default: if (we && wa == 2'd1) m_flg = mt ? 1 : 0;
        endcase
        if (mt) m_pin = m_lvl;
        if (we) begin
            case (wa)
                2'd0: begin m_hi = wd; m_hi_ok = 1; m_armed = 0; end
                2'd1: begin m_lo = wd; m_lo_ok = 1; m_armed = 1; end
                2'd2: begin m_lvl = wd[0]; m_ie = wd[1]; end
                default: ;
            endcase
        end
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0; cnt_tick = 1'b0;
        check(cmp_pin === m_pin, "R4", {15'h0, cmp_pin}, {15'h0, m_pin});
        check(irq === (m_flg != 0 && m_ie), "R7", {15'h0, irq}, {15'h0, (m_flg != 0 && m_ie)});
    endtask

    task automatic expect_bit(input logic act, input logic exp, input string tag);
        check(act === exp, tag, {15'h0, act}, {15'h0, exp});
    endtask

    initial begin
        #2_000_000;
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        expect_bit(cmp_pin, 1'b0, "R1");
        expect_bit(irq, 1'b0, "R1");
        cyc(0, 0, 0, 1, 2'd2, 0, 0, "R1");
        cyc(0, 0, 0, 1, 2'd3, 0, 0, "R1");

        // R2 byte writes and readback
        cyc(1, 2'd0, 8'h12, 0, 0, 0, 0, "R2");
        cyc(1, 2'd1, 8'h34, 0, 0, 0, 0, "R2");
        cyc(0, 0, 0, 1, 2'd0, 0, 0, "R2");
        cyc(0, 0, 0, 1, 2'd1, 0, 0, "R2");
        cyc(1, 2'd1, 8'h35, 1, 2'd0, 0, 0, "R2");
        cyc(0, 0, 0, 1, 2'd0, 0, 0, "R2");
        cyc(1, 2'd1, 8'h34, 1, 2'd1, 0, 0, "R2");

        // R11 control, status write ignored
        cyc(1, 2'd2, 8'hFF, 1, 2'd2, 0, 0, "R11");
        cyc(1, 2'd3, 8'hFF, 1, 2'd2, 0, 0, "R11");
        cyc(0, 0, 0, 1, 2'd3, 0, 0, "R11");

        // R3 match sets flag and pin
        cyc(0, 0, 0, 0, 0, 1, 16'h1234, "R3");
        expect_bit(cmp_pin, 1'b1, "R3");
        expect_bit(irq, 1'b1, "R3");
        cyc(0, 0, 0, 1, 2'd3, 0, 0, "R3");

        // R4 level copied while flag already set
        cyc(1, 2'd2, 8'h02, 0, 0, 0, 0, "R4");
        cyc(0, 0, 0, 0, 0, 1, 16'h1234, "R4");
        expect_bit(cmp_pin, 1'b0, "R4");

        // R8 no change without strobe or equality
        cyc(1, 2'd2, 8'h03, 0, 0, 0, 0, "R8");
        cyc(0, 0, 0, 0, 0, 0, 16'h1234, "R8");
        expect_bit(cmp_pin, 1'b0, "R8");
        cyc(0, 0, 0, 0, 0, 1, 16'h1235, "R8");
        expect_bit(cmp_pin, 1'b0, "R8");

        // R9 clearing sequence
        cyc(1, 2'd1, 8'h34, 0, 0, 0, 0, "R9");
        expect_bit(irq, 1'b0, "R9");
        cyc(0, 0, 0, 0, 0, 1, 16'h1234, "R9");
        expect_bit(irq, 1'b1, "R9");
        cyc(1, 2'd1, 8'h34, 0, 0, 0, 0, "R9");
        expect_bit(irq, 1'b1, "R9");
        cyc(0, 0, 0, 1, 2'd3, 0, 0, "R9");
        cyc(1, 2'd1, 8'h34, 0, 0, 0, 0, "R9");
        expect_bit(irq, 1'b0, "R9");

        // R10 clear coinciding with a match
        cyc(0, 0, 0, 0, 0, 1, 16'h1234, "R10");
        cyc(0, 0, 0, 1, 2'd3, 0, 0, "R10");
        cyc(1, 2'd1, 8'h34, 0, 0, 1, 16'h1234, "R10");
        expect_bit(irq, 1'b1, "R10");
        cyc(0, 0, 0, 1, 2'd3, 0, 0, "R10");

        // R5 high write inhibits until low write
        cyc(1, 2'd2, 8'h02, 0, 0, 0, 0, "R5");
        cyc(1, 2'd0, 8'h56, 1, 2'd3, 0, 0, "R5");
        cyc(0, 0, 0, 1, 2'd3, 0, 0, "R11");
        cyc(0, 0, 0, 0, 0, 1, 16'h5634, "R5");
        expect_bit(cmp_pin, 1'b1, "R5");
        cyc(1, 2'd1, 8'h78, 0, 0, 0, 0, "R5");
        cyc(0, 0, 0, 0, 0, 1, 16'h5678, "R5");
        expect_bit(cmp_pin, 1'b0, "R5");

        // R6 low-only write keeps matching enabled
        cyc(1, 2'd2, 8'h03, 0, 0, 0, 0, "R6");
        cyc(1, 2'd1, 8'h9A, 0, 0, 0, 0, "R6");
        cyc(0, 0, 0, 0, 0, 1, 16'h569A, "R6");
        expect_bit(cmp_pin, 1'b1, "R6");

        // R7 enable gates the request
        cyc(1, 2'd2, 8'h01, 0, 0, 0, 0, "R7");
        expect_bit(irq, 1'b0, "R7");

        // constrained random mix
        for (int i = 0; i < 4000; i++) begin
            bit we, re, tk;
            logic [1:0] wa, ra;
            logic [7:0] wd;
            logic [15:0] cv;
            we = ($urandom % 4) == 0;
            re = ($urandom % 3) == 0;
            tk = ($urandom % 2) == 0;
            wa = 2'($urandom % 4);
            ra = 2'($urandom % 4);
            wd = 8'($urandom);
            if (($urandom % 3) != 0) wd[7:2] = 6'h0;
            cv = (($urandom % 2) == 0) ? {m_hi, m_lo} : 16'($urandom);
            cyc(we, wa, wd, re, ra, tk, cv, "R2");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule